// File: doc/BRIEF.md
# NAND Column Random-Read Sequencer

This block is a host-side controller for an asynchronous NAND-style byte bus. A page has already been loaded into the die's cache register. The block moves the die's read pointer to any byte of that register and then streams out a requested number of bytes. For each request it first checks the die's two ready flags. It then drives the pointer-move command: an opcode cycle, two column address cycles and a confirm opcode cycle. After the write-to-read gap it pulses the read strobe once per byte. Each captured byte goes to the host over a valid/ready port.

Some targets hold several dies. For these, a mode input adds a die-select status command, with its row address cycles, in front of the pointer move, so that only one die drives the bus. The die stays in output mode after a sequence. A follow-on request can therefore resume streaming from the next column without any command cycles. All bus timings are parameters counted in clock cycles.

Top module: `nand_colread_seq`

## Requirements
- R1: A full sequence latches, on rising edges of `nand_we_n`, the opcode 0x05, then the column low byte, then the column high byte (column zero-extended to 16 bits), then the opcode 0xE0. Opcode cycles have `nand_cle`=1 and `nand_ale`=0. Address cycles have `nand_ale`=1 and `nand_cle`=0. Each write pulse is low for T_WL cycles and high for at least T_WH cycles.
- R2: A request is accepted only when `die_rdy`=1 and either `die_ardy`=1 or `cache_rd_active`=1. Otherwise `err` pulses high for one cycle, `busy` stays low and no bus cycle is driven.
- R3: With `req_multi_die`=1, a full sequence is preceded by opcode 0x78 and then ROW_CYC address cycles that carry `req_row`, least significant byte first.
- R4: At least T_WHR cycles pass between the rising write edge of the 0xE0 cycle and the first falling edge of `nand_re_n`.
- R5: Each byte is read with `nand_re_n` low for exactly T_RL cycles. `nand_dq_in` is captured on the edge that ends the low phase. Bytes reach `dout_data` in ascending column order, starting at the requested column, and any column value is accepted.
- R6: While `dout_valid`=1 and `dout_ready`=0, `dout_data` stays stable and `nand_re_n` stays high. Exactly `req_count` bytes are delivered, with none dropped.
- R7: `cur_col` takes the requested column when a full sequence is accepted and rises by one for each byte read.
- R8: A request with `req_cont`=1, made after a completed full sequence, drives no write cycle. It reads `req_count` bytes starting at the current `cur_col`.
- R9: `busy` is high from acceptance until at least T_RHW cycles after the last rising edge of `nand_re_n`. No write cycle starts earlier than that gap. While `busy` is low, both strobes are high and the bus output is disabled.
- R10: After reset, `busy`, `err`, `nand_cle`, `nand_ale`, `nand_dq_oe` and `dout_valid` are low, and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_col | input | COL_W | Start column in the cache register |
| req_count | input | CNT_W | Number of bytes to read (nonzero) |
| req_row | input | 8*ROW_CYC | Row address used by the die-select step |
| req_multi_die | input | 1 | Insert the die-select status step |
| req_cont | input | 1 | Resume streaming without command cycles |
| die_rdy | input | 1 | Die ready flag |
| die_ardy | input | 1 | Die array ready flag |
| cache_rd_active | input | 1 | A cache read is in progress on the die |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | One-cycle pulse on a rejected request |
| cur_col | output | COL_W | Current column pointer |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the bus |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Byte read from the bus |
| dout_valid | output | 1 | Host byte valid |
| dout_data | output | 8 | Host byte |
| dout_ready | input | 1 | Host ready |

## Verification
The assertions take for granted that `dout_ready` changes only between clock edges and that the die flags stay steady for as long as a request is pending. They also assume `req_count` is never zero. The bench drives every input shortly after the rising edge. It holds the die flags constant around each request and draws counts from 1 to 16. It keeps random columns far enough below the top of the range that the column pointer does not wrap.

// File: rtl/ncr_pkg.sv
// Shared opcodes, bus cycle record and sequencer states.
// Assumes an 8-bit asynchronous NAND-style data bus.
package ncr_pkg;
    localparam logic [7:0] OP_DIE_SEL = 8'h78;
    localparam logic [7:0] OP_COL_SET = 8'h05;
    localparam logic [7:0] OP_COL_GO  = 8'hE0;

    typedef struct packed {
        logic       cle;
        logic       ale;
        logic [7:0] data;
    } bus_cycle_t;

    typedef enum logic [3:0] {
        S_IDLE, S_SEL_CMD, S_SEL_ADR, S_SET_CMD, S_COL_LO,
        S_COL_HI, S_GO_CMD, S_WHR, S_READ, S_RHW
    } seq_state_t;
endpackage

// File: rtl/ncr_wr_cycle.sv
// One bus write cycle: holds CLE/ALE/data for the whole cycle, drives the
// write strobe low for T_WL cycles and high for T_WH cycles, then pulses done.
// Assumes start arrives only while the cycle engine is idle; T_WL, T_WH >= 1.
module ncr_wr_cycle
    import ncr_pkg::*;
#(
    parameter int T_WL = 2,
    parameter int T_WH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  bus_cycle_t cyc_in,
    output logic       we_n,
    output logic       cle,
    output logic       ale,
    output logic [7:0] dq,
    output logic       oe,
    output logic       done
);
    localparam int TMAX = (T_WL > T_WH) ? T_WL : T_WH;
    localparam int CW   = $clog2(TMAX + 1);

    typedef enum logic [1:0] {W_IDLE, W_LOW, W_HIGH} wph_t;

    wph_t          ph;
    logic [CW-1:0] cnt;
    bus_cycle_t    cyc;

    // Phase counter for one write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= W_IDLE;
            cnt  <= '0;
            we_n <= 1'b1;
            cyc  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                W_IDLE: if (start) begin
                    ph   <= W_LOW;
                    cnt  <= CW'(T_WL - 1);
                    we_n <= 1'b0;
                    cyc  <= cyc_in;
                end
                W_LOW: if (cnt == '0) begin
                    ph   <= W_HIGH;
                    we_n <= 1'b1;
                    cnt  <= CW'(T_WH - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: if (cnt == '0) begin
                    ph   <= W_IDLE;
                    done <= 1'b1;
                    cyc  <= '0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Bus fields follow the held cycle record.
    always_comb begin
        cle = cyc.cle;
        ale = cyc.ale;
        dq  = cyc.data;
        oe  = (ph != W_IDLE);
    end
endmodule

// File: rtl/ncr_rd_stream.sv
// Reads n_bytes bytes with the read strobe: low for T_RL cycles, byte captured
// on the edge ending the low phase, then high for at least T_RH cycles and
// until the host has taken the byte. Pulses sample per byte and done at end.
// Assumes start only while idle; T_RL, T_RH >= 1.
module ncr_rd_stream #(
    parameter int T_RL  = 2,
    parameter int T_RH  = 2,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] n_bytes,
    input  logic [7:0]       dq_in,
    input  logic             out_ready,
    output logic             re_n,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             sample,
    output logic             done
);
    localparam int TMAX = (T_RL > T_RH) ? T_RL : T_RH;
    localparam int CW   = $clog2(TMAX + 1);

    typedef enum logic [1:0] {R_IDLE, R_LOW, R_HIGH} rph_t;

    rph_t             ph;
    logic [CW-1:0]    cnt;
    logic [CNT_W-1:0] rem;

    // Strobe phases, byte capture and host handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= R_IDLE;
            cnt       <= '0;
            rem       <= '0;
            re_n      <= 1'b1;
            out_valid <= 1'b0;
            out_data  <= '0;
            sample    <= 1'b0;
            done      <= 1'b0;
        end else begin
            sample <= 1'b0;
            done   <= 1'b0;
            case (ph)
                R_IDLE: if (start) begin
                    if (n_bytes == '0) begin
                        done <= 1'b1;
                    end else begin
                        ph   <= R_LOW;
                        re_n <= 1'b0;
                        cnt  <= CW'(T_RL - 1);
                        rem  <= n_bytes;
                    end
                end
                R_LOW: if (cnt == '0) begin
                    ph        <= R_HIGH;
                    re_n      <= 1'b1;
                    out_data  <= dq_in;
                    out_valid <= 1'b1;
                    sample    <= 1'b1;
                    rem       <= rem - 1'b1;
                    cnt       <= CW'(T_RH - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: begin
                    if (out_valid && out_ready) out_valid <= 1'b0;
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    if (cnt == '0 && (!out_valid || out_ready)) begin
                        if (rem != '0) begin
                            ph   <= R_LOW;
                            re_n <= 1'b0;
                            cnt  <= CW'(T_RL - 1);
                        end else begin
                            ph   <= R_IDLE;
                            done <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/nand_colread_seq.sv
// Column random-read sequencer. Gates a request on the die ready flags,
// optionally selects one die with a status command, moves the cache column
// pointer, waits T_WHR, streams req_count bytes, then waits T_RHW.
// Assumes req_count is nonzero and COL_W <= 16.
module nand_colread_seq
    import ncr_pkg::*;
#(
    parameter int COL_W   = 12,
    parameter int CNT_W   = 8,
    parameter int ROW_CYC = 3,
    parameter int T_WL    = 2,
    parameter int T_WH    = 2,
    parameter int T_RL    = 2,
    parameter int T_RH    = 2,
    parameter int T_WHR   = 6,
    parameter int T_RHW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [COL_W-1:0]     req_col,
    input  logic [CNT_W-1:0]     req_count,
    input  logic [8*ROW_CYC-1:0] req_row,
    input  logic                 req_multi_die,
    input  logic                 req_cont,
    input  logic                 die_rdy,
    input  logic                 die_ardy,
    input  logic                 cache_rd_active,
    output logic                 busy,
    output logic                 err,
    output logic [COL_W-1:0]     cur_col,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_we_n,
    output logic                 nand_re_n,
    output logic [7:0]           nand_dq_out,
    output logic                 nand_dq_oe,
    input  logic [7:0]           nand_dq_in,
    output logic                 dout_valid,
    output logic [7:0]           dout_data,
    input  logic                 dout_ready
);
    localparam int GMAX = (T_WHR > T_RHW) ? T_WHR : T_RHW;
    localparam int GW   = $clog2(GMAX + 1);
    localparam int IW   = (ROW_CYC > 1) ? $clog2(ROW_CYC) : 1;

    seq_state_t           state;
    logic                 issued;
    logic [IW-1:0]        idx;
    logic [GW-1:0]        gap;
    logic [COL_W-1:0]     col_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [8*ROW_CYC-1:0] row_q;
    logic                 out_mode;
    logic                 ready_ok;
    logic                 in_wr;
    logic                 wr_start;
    logic                 wr_done;
    logic                 rd_start;
    logic                 rd_done;
    logic                 rd_sample;
    logic [15:0]          col_wide;
    bus_cycle_t           wr_cyc;

    // Request gating and engine launch.
    always_comb begin
        ready_ok = die_rdy && (die_ardy || cache_rd_active);
        col_wide = 16'(col_q);
        in_wr    = (state == S_SEL_CMD) || (state == S_SEL_ADR) ||
                   (state == S_SET_CMD) || (state == S_COL_LO)  ||
                   (state == S_COL_HI)  || (state == S_GO_CMD);
        wr_start = in_wr && !issued;
        rd_start = (state == S_READ) && !issued;
    end

    // Bus cycle content for the current write state.
    always_comb begin
        case (state)
            S_SEL_CMD: wr_cyc = '{cle: 1'b1, ale: 1'b0, data: OP_DIE_SEL};
            S_SEL_ADR: wr_cyc = '{cle: 1'b0, ale: 1'b1, data: row_q[{idx, 3'b000} +: 8]};
            S_SET_CMD: wr_cyc = '{cle: 1'b1, ale: 1'b0, data: OP_COL_SET};
            S_COL_LO:  wr_cyc = '{cle: 1'b0, ale: 1'b1, data: col_wide[7:0]};
            S_COL_HI:  wr_cyc = '{cle: 1'b0, ale: 1'b1, data: col_wide[15:8]};
            S_GO_CMD:  wr_cyc = '{cle: 1'b1, ale: 1'b0, data: OP_COL_GO};
            default:   wr_cyc = '0;
        endcase
    end

    // Sequence state, gap timers and column pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            issued   <= 1'b0;
            idx      <= '0;
            gap      <= '0;
            col_q    <= '0;
            cnt_q    <= '0;
            row_q    <= '0;
            out_mode <= 1'b0;
            err      <= 1'b0;
        end else begin
            err <= 1'b0;
            if (wr_start || rd_start) issued <= 1'b1;
            case (state)
                S_IDLE: if (req_valid) begin
                    if (!ready_ok) begin
                        err <= 1'b1;
                    end else begin
                        cnt_q <= req_count;
                        if (req_cont && out_mode) begin
                            state <= S_READ;
                        end else begin
                            col_q <= req_col;
                            row_q <= req_row;
                            idx   <= '0;
                            state <= req_multi_die ? S_SEL_CMD : S_SET_CMD;
                        end
                    end
                end
                S_SEL_CMD: if (wr_done) begin
                    issued <= 1'b0;
                    state  <= S_SEL_ADR;
                end
                S_SEL_ADR: if (wr_done) begin
                    issued <= 1'b0;
                    if (idx == IW'(ROW_CYC - 1)) state <= S_SET_CMD;
                    else idx <= idx + 1'b1;
                end
                S_SET_CMD: if (wr_done) begin
                    issued <= 1'b0;
                    state  <= S_COL_LO;
                end
                S_COL_LO: if (wr_done) begin
                    issued <= 1'b0;
                    state  <= S_COL_HI;
                end
                S_COL_HI: if (wr_done) begin
                    issued <= 1'b0;
                    state  <= S_GO_CMD;
                end
                S_GO_CMD: if (wr_done) begin
                    issued   <= 1'b0;
                    out_mode <= 1'b1;
                    gap      <= GW'(T_WHR - 1);
                    state    <= S_WHR;
                end
                S_WHR: if (gap == '0) state <= S_READ;
                       else gap <= gap - 1'b1;
                S_READ: begin
                    if (rd_sample) col_q <= col_q + 1'b1;
                    if (rd_done) begin
                        issued <= 1'b0;
                        gap    <= GW'(T_RHW - 1);
                        state  <= S_RHW;
                    end
                end
                default: if (gap == '0) state <= S_IDLE;
                         else gap <= gap - 1'b1;
            endcase
        end
    end

    assign busy    = (state != S_IDLE);
    assign cur_col = col_q;

    ncr_wr_cycle #(.T_WL(T_WL), .T_WH(T_WH)) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_start),
        .cyc_in (wr_cyc),
        .we_n   (nand_we_n),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .dq     (nand_dq_out),
        .oe     (nand_dq_oe),
        .done   (wr_done)
    );

    ncr_rd_stream #(.T_RL(T_RL), .T_RH(T_RH), .CNT_W(CNT_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rd_start),
        .n_bytes   (cnt_q),
        .dq_in     (nand_dq_in),
        .out_ready (dout_ready),
        .re_n      (nand_re_n),
        .out_valid (dout_valid),
        .out_data  (dout_data),
        .sample    (rd_sample),
        .done      (rd_done)
    );
endmodule

// File: rtl/ncr_seq_checker.sv
// Protocol checker for nand_colread_seq, attached by bind below.
// Assumes dout_ready and die flags change only between clock edges.
module ncr_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       err,
    input logic       die_rdy,
    input logic       die_ardy,
    input logic       cache_rd_active,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_dq_oe,
    input logic       dout_valid,
    input logic [7:0] dout_data,
    input logic       dout_ready
);
    AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(die_rdy && (die_ardy || cache_rd_active))); // R2
    AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy); // R2
    AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R1
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R5
    AST_READ_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe); // R5
    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data))); // R6
    AST_STALL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !dout_ready) |=> nand_re_n); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n && !nand_dq_oe)); // R9
endmodule

bind nand_colread_seq ncr_seq_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .busy            (busy),
    .err             (err),
    .die_rdy         (die_rdy),
    .die_ardy        (die_ardy),
    .cache_rd_active (cache_rd_active),
    .nand_cle        (nand_cle),
    .nand_ale        (nand_ale),
    .nand_we_n       (nand_we_n),
    .nand_re_n       (nand_re_n),
    .nand_dq_oe      (nand_dq_oe),
    .dout_valid      (dout_valid),
    .dout_data       (dout_data),
    .dout_ready      (dout_ready)
);

// File: tb/nand_colread_seq_tb.sv
`timescale 1ns/1ps
module nand_colread_seq_tb;
    localparam int T_WL = 2, T_WH = 2, T_WHR = 6, T_RHW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_col = '0;
    logic [7:0]  req_count = '0;
    logic [23:0] req_row = '0;
    logic        req_multi_die = 1'b0, req_cont = 1'b0;
    logic        die_rdy = 1'b1, die_ardy = 1'b1, cache_rd_active = 1'b0;
    logic        busy, err, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [11:0] cur_col;
    logic [7:0]  nand_dq_out, nand_dq_in, dout_data;
    logic        dout_valid;
    logic        dout_ready = 1'b1;

    int checks = 0, errors = 0;
    int bp_mode = 0;

    always #2.5 clk = ~clk;

    // Die model: cache byte as a function of its column.
    function automatic logic [7:0] cache_byte(input logic [15:0] c);
        return (c[7:0] * 8'd13) ^ c[15:8] ^ 8'h5A;
    endfunction

    logic [15:0] mcol = '0;
    assign nand_dq_in = cache_byte(mcol);

    nand_colread_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_col(req_col),
        .req_count(req_count), .req_row(req_row), .req_multi_die(req_multi_die),
        .req_cont(req_cont), .die_rdy(die_rdy), .die_ardy(die_ardy),
        .cache_rd_active(cache_rd_active), .busy(busy), .err(err), .cur_col(cur_col),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .dout_valid(dout_valid), .dout_data(dout_data),
        .dout_ready(dout_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Bus monitor: latched write cycles, received bytes, timing gaps.
    logic [9:0] log_c [64];
    int log_n = 0;
    logic [7:0] rx [64];
    int rx_n = 0;
    int cyc = 0, t_e0 = 0, t_re_rise = 0;
    bit pend_e0 = 0, rd_since = 0;
    int viol_whr = 0, viol_rhw = 0;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_busy = 1'b0;
    int aph = 0;
    logic [7:0] alo = '0;

    always @(negedge clk) begin
        cyc++;
        if (!prev_we && nand_we_n) begin
            if (log_n < 64) log_c[log_n] = {nand_cle, nand_ale, nand_dq_out};
            log_n++;
            if (nand_cle && nand_dq_out == 8'h05) aph = 1;
            else if (nand_ale && aph == 1) begin alo = nand_dq_out; aph = 2; end
            else if (nand_ale && aph == 2) begin mcol = {nand_dq_out, alo}; aph = 0; end
            if (nand_cle && nand_dq_out == 8'hE0) begin t_e0 = cyc; pend_e0 = 1; end
        end
        if (prev_we && !nand_we_n && rd_since) begin
            if (cyc - t_re_rise < T_RHW) viol_rhw++;
            rd_since = 0;
        end
        if (prev_re && !nand_re_n && pend_e0) begin
            if (cyc - t_e0 < T_WHR) viol_whr++;
            pend_e0 = 0;
        end
        if (!prev_re && nand_re_n) begin
            t_re_rise = cyc;
            rd_since = 1;
            mcol = mcol + 1'b1;
        end
        if (prev_busy && !busy && cyc - t_re_rise < T_RHW) viol_rhw++;
        if (dout_valid && dout_ready) begin
            if (rx_n < 64) rx[rx_n] = dout_data;
            rx_n++;
        end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
        prev_busy = busy;
    end

    // Host ready: always high, or random stalls in backpressure mode.
    always @(posedge clk) begin
        #1;
        dout_ready = (bp_mode == 0) ? 1'b1 : (($urandom % 4) == 0);
    end

    bit tb_mode = 0;
    logic [15:0] tb_col = '0;

    task automatic run_txn(input logic [11:0] col, input int cnt, input bit multi,
                           input logic [23:0] row, input bit cont,
                           input bit rdy, input bit ardy, input bit cra);
        bit ok;
        bit skip;
        logic [15:0] start;
        logic [9:0] exp_c [12];
        int exp_n = 0;
        ok = rdy && (ardy || cra);
        skip = cont && tb_mode;
        @(posedge clk); #1;
        log_n = 0; rx_n = 0; viol_whr = 0; viol_rhw = 0;
        die_rdy = rdy; die_ardy = ardy; cache_rd_active = cra;
        req_col = col; req_count = 8'(cnt); req_multi_die = multi;
        req_row = row; req_cont = cont; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        if (!ok) begin
            chk(err == 1'b1, "R2 err pulse", err, 1);
            chk(busy == 1'b0, "R2 busy low", busy, 0);
            repeat (20) @(negedge clk);
            chk(log_n == 0 && rx_n == 0, "R2 no bus", log_n + rx_n, 0);
            chk(err == 1'b0, "R2 err one cycle", err, 0);
            return;
        end
        chk(busy == 1'b1 && err == 1'b0, "R9 busy on accept", busy, 1);
        while (busy) @(negedge clk);
        start = skip ? tb_col : {4'h0, col};
        if (!skip) begin
            if (multi) begin
                exp_c[exp_n++] = {2'b10, 8'h78};
                for (int i = 0; i < 3; i++) exp_c[exp_n++] = {2'b01, row[8*i +: 8]};
            end
            exp_c[exp_n++] = {2'b10, 8'h05};
            exp_c[exp_n++] = {2'b01, start[7:0]};
            exp_c[exp_n++] = {2'b01, start[15:8]};
            exp_c[exp_n++] = {2'b10, 8'hE0};
        end
        chk(log_n == exp_n, skip ? "R8 no write cycles" : "R1 R3 cycle count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            chk(log_c[i] == exp_c[i], multi ? "R3 bus cycle" : "R1 bus cycle",
                int'(log_c[i]), int'(exp_c[i]));
        chk(rx_n == cnt, "R6 byte count", rx_n, cnt);
        for (int i = 0; i < cnt && i < rx_n; i++)
            chk(rx[i] == cache_byte(start + 16'(i)), skip ? "R8 byte" : "R5 byte",
                rx[i], cache_byte(start + 16'(i)));
        chk(cur_col == 12'(start + 16'(cnt)), "R7 cur_col", cur_col, 12'(start + 16'(cnt)));
        chk(viol_whr == 0, "R4 write-to-read gap", viol_whr, 0);
        chk(viol_rhw == 0, "R9 read-to-write gap", viol_rhw, 0);
        tb_mode = 1;
        tb_col = start + 16'(cnt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0951);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && err == 0 && nand_cle == 0 && nand_ale == 0, "R10 control low",
            {busy, err, nand_cle, nand_ale}, 0);
        chk(nand_we_n == 1 && nand_re_n == 1 && nand_dq_oe == 0 && dout_valid == 0,
            "R10 strobes idle", {nand_we_n, nand_re_n, nand_dq_oe, dout_valid}, 4'b1100);
        // Directed corners.
        run_txn(12'h000, 1, 0, 24'h0, 0, 1, 1, 0);
        run_txn(12'hAB7, 5, 1, 24'h3C_2B_1A, 0, 1, 1, 0);
        run_txn(12'h000, 3, 0, 24'h0, 1, 1, 1, 0);
        run_txn(12'h123, 4, 0, 24'h0, 0, 0, 1, 1);
        run_txn(12'h123, 4, 0, 24'h0, 0, 1, 0, 0);
        run_txn(12'h401, 6, 0, 24'h0, 0, 1, 0, 1);
        bp_mode = 1;
        run_txn(12'h7FF, 16, 0, 24'h0, 0, 1, 1, 0);
        run_txn(12'h000, 9, 0, 24'h0, 1, 1, 1, 0);
        // Random mix.
        for (int n = 0; n < 40; n++) begin
            int cnt;
            bit cont;
            cnt = 1 + ($urandom % 16);
            cont = (($urandom % 4) == 0) && (tb_col + 16'(cnt) < 16'd4095);
            bp_mode = $urandom % 2;
            run_txn(12'($urandom % 4000), cnt, $urandom % 2, 24'($urandom), cont,
                    ($urandom % 8) != 0, $urandom % 2, $urandom % 2);
        end
        bp_mode = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule